// File: doc/BRIEF.md
# Load/Store Unit with Stall Handshake

This unit sits between a single-cycle RV32I core and a slow data memory whose response time varies. The core presents an access mode (off, load or store), the instruction's funct3 field, a 32-bit base register value, a signed 12-bit displacement and the store data. The unit adds the base and the sign-extended displacement to form the effective address. It works out which byte lanes of the aligned word the access covers, and then moves those bytes one at a time over a byte-wide request/acknowledge memory port.

Loads are assembled little-endian: the lowest address supplies the least significant byte. The unit then shifts the result into place and extends it to 32 bits with either the sign or zeros. Stores send the store data's low bytes to the matching lanes.

The core holds its program counter while `lsu_busy` is high and `lsu_done` is low. It keeps the mode steady until it sees the single-cycle `lsu_done` pulse. After the pulse it returns the mode to off, and that releases the unit.

The controller has four states. ST_IDLE moves to ST_XFER when an active mode is seen (accept). ST_XFER stays put while bytes remain, and moves to ST_DONE when the last byte is acknowledged (complete). ST_DONE goes to ST_IDLE if the mode is already off (release), and otherwise to ST_HOLD (park). ST_HOLD goes to ST_IDLE once the mode is off (release).

Top module: `rv_memstage_lsu`

## Requirements
- R1: The effective address is `lsu_base` plus `lsu_offset` sign-extended to 32 bits. Each byte request carries the effective address's upper 30 bits with the lane number in bits 1:0.
- R2: Mode codes are 2'b00 off, 2'b01 load, 2'b10 store and 2'b11 off. While the mode is off, `lsu_rdata` is 0 and `lsu_done` is 0.
- R3: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`. Each acknowledge completes one byte, and the lanes of one access go out in ascending order.
- R4: `lsu_done` is a one-cycle pulse in the cycle after the last byte's acknowledge. `lsu_busy` is high from the cycle after acceptance until release.
- R5: A request is accepted only in ST_IDLE. While busy, after done, changing any input starts no memory traffic.
- R6: With the mode off in ST_DONE or ST_HOLD, `lsu_busy` is low in the next cycle.
- R7: A word load returns the byte at address+3 as bits 31:24 and the byte at the address as bits 7:0. For example, bytes 42 EE FF C0 give 0xC0FFEE42.
- R8: funct3 000 is a signed byte load, 001 a signed halfword load and 010 a word load. 100 is an unsigned byte load and 101 an unsigned halfword load. Results are extended to 32 bits.
- R9: Stores cover 1, 2 or 4 lanes from funct3[1:0] (00, 01, other), starting at lane address[1:0]. Lane k receives store-data byte k counted from the access's first lane. Memory bytes outside the covered lanes are left untouched.
- R10: Load data stays stable from the done pulse until release, whatever the mode inputs do. A completed store returns 0.
- R11: After reset, `lsu_busy`, `lsu_done`, `mem_req` and `lsu_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsu_mode | input | 2 | Access mode: 00 off, 01 load, 10 store, 11 off |
| lsu_funct3 | input | 3 | Access width and signedness |
| lsu_base | input | 32 | Base address |
| lsu_offset | input | 12 | Signed displacement |
| lsu_wdata | input | 32 | Store data |
| lsu_rdata | output | 32 | Extended load data, 0 for stores or when off |
| lsu_done | output | 1 | One-cycle completion pulse |
| lsu_busy | output | 1 | Access in progress or result parked |
| mem_req | output | 1 | Byte request to memory |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Memory acknowledge, one cycle per byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |

## Verification
The bench goes after byte order and extension. It uses a word whose top byte has bit 7 set, read as signed and unsigned byte and halfword from different lanes, so a design that swaps lanes or extends the wrong bit returns a visibly wrong value. It puts a store at a negative displacement from the stack top next to preset bytes, where a wrong borrow in the address or a mask that covers too many lanes lands the write elsewhere or corrupts a neighbour. It varies the memory latency across 1, 3 and 5 cycles and compares `lsu_done` against the last acknowledge on every clock, so a pulse that comes early, late or lasts two cycles shows up. It changes the inputs while the unit is parked, which exposes a design that re-accepts a request or lets its result drift.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_LOAD  = 2'b01,
        MODE_STORE = 2'b10,
        MODE_RSVD  = 2'b11
    } lsu_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_DONE,
        ST_HOLD
    } lsu_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE,
        SZ_HALF,
        SZ_WORD
    } lsu_size_e;

    // Access width from the low two funct3 bits
    function automatic lsu_size_e size_of(input logic [1:0] code);
        unique case (code)
            2'b00:   return SZ_BYTE;
            2'b01:   return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
// Effective address, covered lane mask and lane-placed store data
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 12,
    parameter int LANE_W = 8
) (
    input  logic [ADDR_W-1:0]          base,
    input  logic [OFS_W-1:0]           offset,
    input  lsu_size_e                  sz,
    input  logic [DATA_W-1:0]          wdata,
    output logic [ADDR_W-1:0]          ea,
    output logic [DATA_W/LANE_W-1:0]   lane_mask,
    output logic [DATA_W-1:0]          placed
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int SEL_W = $clog2(LANES);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [2*LANES-1:0] span;
    logic [2*LANES-1:0] span_sh;
    logic [SEL_W-1:0]   first_lane;

    assign ea         = base + {{EXT_W{offset[OFS_W-1]}}, offset};
    assign first_lane = ea[SEL_W-1:0];

    always_comb begin
        unique case (sz)
            SZ_BYTE: span = (2*LANES)'(1);
            SZ_HALF: span = (2*LANES)'(3);
            default: span = {{LANES{1'b0}}, {LANES{1'b1}}};
        endcase
    end

    // Lanes past the end of the word fall off (misalignment is not handled)
    assign span_sh   = span << first_lane;
    assign lane_mask = span_sh[LANES-1:0];
    assign placed    = wdata << (first_lane * LANE_W);

endmodule

// File: rtl/lsu_lane_pick.sv
// Lowest pending lane: one-hot and encoded forms
module lsu_lane_pick #(
    parameter int LANES = 4,
    parameter int SEL_W = 2
) (
    input  logic [LANES-1:0] pend,
    output logic [LANES-1:0] onehot,
    output logic [SEL_W-1:0] idx
);
    logic [LANES:0] below;

    assign below[0] = 1'b0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign onehot[i]  = pend[i] & ~below[i];
        assign below[i+1] = below[i] | pend[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < LANES; i++) begin
            if (onehot[i]) idx = idx | SEL_W'(i);
        end
    end

endmodule

// File: rtl/lsu_load_align.sv
// Shift gathered lanes down and extend to full width
module lsu_load_align
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic [DATA_W-1:0] gathered,
    input  logic [SEL_W-1:0]  lane_ofs,
    input  lsu_size_e         sz,
    input  logic              sgn,
    output logic [DATA_W-1:0] value
);
    localparam int HALF_W = 2 * LANE_W;

    logic [DATA_W-1:0] sh;

    assign sh = gathered >> (lane_ofs * LANE_W);

    always_comb begin
        unique case (sz)
            SZ_BYTE: value = {{(DATA_W-LANE_W){sgn & sh[LANE_W-1]}}, sh[LANE_W-1:0]};
            SZ_HALF: value = {{(DATA_W-HALF_W){sgn & sh[HALF_W-1]}}, sh[HALF_W-1:0]};
            default: value = sh;
        endcase
    end

endmodule

// File: rtl/rv_memstage_lsu.sv
module rv_memstage_lsu
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 12,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lsu_mode,
    input  logic [2:0]        lsu_funct3,
    input  logic [ADDR_W-1:0] lsu_base,
    input  logic [OFS_W-1:0]  lsu_offset,
    input  logic [DATA_W-1:0] lsu_wdata,
    output logic [DATA_W-1:0] lsu_rdata,
    output logic              lsu_done,
    output logic              lsu_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LANE_W-1:0] mem_rdata
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int SEL_W = $clog2(LANES);

    lsu_state_e        state_q, state_d;
    logic [ADDR_W-1:0] ea_q;
    logic [2:0]        f3_q;
    logic              store_q;
    logic [LANES-1:0]  pend_q;
    logic [DATA_W-1:0] wlane_q;
    logic [DATA_W-1:0] gather_q;

    logic              mode_load, mode_store, mode_act;
    logic [ADDR_W-1:0] ea_in;
    logic [LANES-1:0]  mask_in;
    logic [DATA_W-1:0] placed_in;
    logic [LANES-1:0]  pick_oh;
    logic [SEL_W-1:0]  pick_idx;
    logic              last_lane;
    logic [DATA_W-1:0] load_val;

    assign mode_load  = (lsu_mode == MODE_LOAD);
    assign mode_store = (lsu_mode == MODE_STORE);
    assign mode_act   = mode_load | mode_store;

    lsu_addr_gen #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W),
        .LANE_W (LANE_W)
    ) u_addr (
        .base      (lsu_base),
        .offset    (lsu_offset),
        .sz        (size_of(lsu_funct3[1:0])),
        .wdata     (lsu_wdata),
        .ea        (ea_in),
        .lane_mask (mask_in),
        .placed    (placed_in)
    );

    lsu_lane_pick #(
        .LANES (LANES),
        .SEL_W (SEL_W)
    ) u_pick (
        .pend   (pend_q),
        .onehot (pick_oh),
        .idx    (pick_idx)
    );

    lsu_load_align #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W),
        .SEL_W  (SEL_W)
    ) u_align (
        .gathered (gather_q),
        .lane_ofs (ea_q[SEL_W-1:0]),
        .sz       (size_of(f3_q[1:0])),
        .sgn      (~f3_q[2]),
        .value    (load_val)
    );

    assign last_lane = ((pend_q & ~pick_oh) == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (mode_act)              state_d = ST_XFER;
            ST_XFER: if (mem_ack && last_lane)  state_d = ST_DONE;
            ST_DONE: state_d = mode_act ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!mode_act)             state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Access context and byte gathering
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q     <= '0;
            f3_q     <= '0;
            store_q  <= 1'b0;
            pend_q   <= '0;
            wlane_q  <= '0;
            gather_q <= '0;
        end else if (state_q == ST_IDLE && mode_act) begin
            ea_q     <= ea_in;
            f3_q     <= lsu_funct3;
            store_q  <= mode_store;
            pend_q   <= mask_in;
            wlane_q  <= placed_in;
            gather_q <= '0;
        end else if (state_q == ST_XFER && mem_ack) begin
            pend_q <= pend_q & ~pick_oh;
            if (!store_q) begin
                for (int i = 0; i < LANES; i++) begin
                    if (pick_oh[i]) gather_q[i*LANE_W +: LANE_W] <= mem_rdata;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        lsu_done  = 1'b0;
        lsu_busy  = 1'b0;
        lsu_rdata = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: begin
                lsu_busy  = 1'b1;
                mem_req   = 1'b1;
                mem_we    = store_q;
                mem_addr  = {ea_q[ADDR_W-1:SEL_W], pick_idx};
                mem_wdata = wlane_q[pick_idx*LANE_W +: LANE_W];
            end
            ST_DONE: begin
                lsu_busy  = 1'b1;
                lsu_done  = mode_act;
                lsu_rdata = (mode_act && !store_q) ? load_val : '0;
            end
            ST_HOLD: begin
                lsu_busy  = 1'b1;
                lsu_rdata = (mode_act && !store_q) ? load_val : '0;
            end
            default: ;
        endcase
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R3
    lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req || (mem_addr[SEL_W-1:0] > $past(mem_addr[SEL_W-1:0]))));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsu_done |=> !lsu_done);

    // R4
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsu_done |-> lsu_busy);

    // R5
    no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsu_done |=> !mem_req);

    // R6
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lsu_busy) |-> !$past(mode_act));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsu_done |=> (!mode_act || $stable(lsu_rdata)));

endmodule

// File: tb/tb_rv_memstage_lsu.sv
`timescale 1ns/1ps
module tb_rv_memstage_lsu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  lsu_mode = 2'b00;
    logic [2:0]  lsu_funct3 = 3'b000;
    logic [31:0] lsu_base = '0;
    logic [11:0] lsu_offset = '0;
    logic [31:0] lsu_wdata = '0;
    logic [31:0] lsu_rdata;
    logic        lsu_done, lsu_busy;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    always #2 clk = ~clk;

    rv_memstage_lsu dut (
        .clk(clk), .rst_n(rst_n),
        .lsu_mode(lsu_mode), .lsu_funct3(lsu_funct3), .lsu_base(lsu_base),
        .lsu_offset(lsu_offset), .lsu_wdata(lsu_wdata),
        .lsu_rdata(lsu_rdata), .lsu_done(lsu_done), .lsu_busy(lsu_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Behavioural memory and reference model state
    logic [7:0]  tmem [256];
    logic [31:0] qa [$];
    logic [7:0]  qd [$];
    int          lat = 1;
    int          wcnt = 0;
    bit          exp_we = 0;
    bit          busy_exp = 0;
    bit          done_seen = 0;
    logic [31:0] exp_rdata = '0;
    int          total = 0;
    int          bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit mode_on();
        return (lsu_mode == 2'b01) || (lsu_mode == 2'b10);
    endfunction

    // One clock: compare outputs with the model, then answer as memory
    task automatic step();
        bit popped_last;
        @(negedge clk);
        popped_last = 0;
        if (mem_ack) begin
            if (qa.size() > 0) begin
                void'(qa.pop_front());
                void'(qd.pop_front());
                popped_last = (qa.size() == 0);
            end
            mem_ack = 1'b0;
            wcnt = 0;
        end
        chk(lsu_done === popped_last, "R4 done timing", 32'(lsu_done), 32'(popped_last));
        if (lsu_done === 1'b1) begin
            done_seen = 1;
            chk(lsu_rdata === exp_rdata, "R7 R8 R10 result", lsu_rdata, exp_rdata);
        end
        chk(lsu_busy === busy_exp, "R4 busy", 32'(lsu_busy), 32'(busy_exp));
        if (qa.size() > 0) begin
            chk(mem_req === 1'b1, "R3 request", 32'(mem_req), 32'd1);
            chk(mem_addr === qa[0], "R1 R3 byte address", mem_addr, qa[0]);
            chk(mem_we === exp_we, "R3 write flag", 32'(mem_we), 32'(exp_we));
            if (exp_we) chk(mem_wdata === qd[0], "R9 store lane", 32'(mem_wdata), 32'(qd[0]));
        end else begin
            chk(mem_req === 1'b0, "R5 no traffic", 32'(mem_req), 32'd0);
        end
        if (!mode_on()) begin
            chk(lsu_rdata === 32'd0 && lsu_done === 1'b0, "R2 off outputs", lsu_rdata, 32'd0);
        end
        if (mem_req === 1'b1 && !mem_ack) begin
            wcnt++;
            if (wcnt >= lat) begin
                mem_ack = 1'b1;
                if (mem_we) tmem[mem_addr[7:0]] = mem_wdata;
                else        mem_rdata = tmem[mem_addr[7:0]];
            end
        end
    endtask

    task automatic run_op(input logic [1:0] md, input logic [2:0] f3, input logic [31:0] b,
                          input logic [11:0] o, input logic [31:0] wd, input int l, input int hold);
        logic [31:0] ea;
        logic [7:0]  by [4];
        int n;
        ea = b + {{20{o[11]}}, o};
        n  = (f3[1:0] == 2'b00) ? 1 : ((f3[1:0] == 2'b01) ? 2 : 4);
        lat = l;
        for (int k = 0; k < 4; k++) by[k] = tmem[8'(ea[7:0] + 8'(k))];
        for (int k = 0; k < n; k++) begin
            qa.push_back(ea + 32'(k));
            qd.push_back(wd[8*k +: 8]);
        end
        if (md == 2'b01) begin
            if (n == 1)      exp_rdata = {{24{~f3[2] & by[0][7]}}, by[0]};
            else if (n == 2) exp_rdata = {{16{~f3[2] & by[1][7]}}, by[1], by[0]};
            else             exp_rdata = {by[3], by[2], by[1], by[0]};
        end else begin
            exp_rdata = 32'd0;
        end
        exp_we     = (md == 2'b10);
        lsu_mode   = md;
        lsu_funct3 = f3;
        lsu_base   = b;
        lsu_offset = o;
        lsu_wdata  = wd;
        busy_exp   = 1;
        done_seen  = 0;
        for (int s = 0; s < 300 && !done_seen; s++) step();
        if (!done_seen) chk(0, "R4 done never raised", 32'd0, 32'd1);
        // R5 R10: parked; new inputs must not start traffic, result must not move
        for (int h = 0; h < hold; h++) begin
            lsu_base   = lsu_base + 32'h40;
            lsu_mode   = (h % 2 == 0) ? 2'b10 : 2'b01;
            lsu_funct3 = 3'b010;
            step();
            chk(lsu_rdata === exp_rdata, "R10 parked result", lsu_rdata, exp_rdata);
            chk(lsu_busy === 1'b1, "R5 parked busy", 32'(lsu_busy), 32'd1);
        end
        lsu_mode = 2'b00;
        busy_exp = 0;
        step();
        chk(lsu_busy === 1'b0, "R6 release", 32'(lsu_busy), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) tmem[i] = 8'(i * 7 + 3);
        tmem[8'h10] = 8'h42; tmem[8'h11] = 8'hEE; tmem[8'h12] = 8'hFF; tmem[8'h13] = 8'hC0;
        tmem[8'hFC] = 8'h11; tmem[8'hFD] = 8'h22; tmem[8'hFE] = 8'h33; tmem[8'hFF] = 8'h44;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk(lsu_busy === 1'b0 && lsu_done === 1'b0, "R11 reset busy/done", {lsu_busy, lsu_done}, 32'd0);
        chk(mem_req === 1'b0, "R11 reset req", 32'(mem_req), 32'd0);
        chk(lsu_rdata === 32'd0, "R11 reset rdata", lsu_rdata, 32'd0);
        step();

        // R7 word load, little-endian, latency 3
        run_op(2'b01, 3'b010, 32'h1000_0000, 12'h010, 32'd0, 3, 0);
        chk(exp_rdata === 32'hC0FF_EE42, "R7 word example", exp_rdata, 32'hC0FF_EE42);
        // R8 byte and halfword, signed and unsigned
        run_op(2'b01, 3'b000, 32'h1000_0000, 12'h013, 32'd0, 1, 0);
        chk(exp_rdata === 32'hFFFF_FFC0, "R8 lb", exp_rdata, 32'hFFFF_FFC0);
        run_op(2'b01, 3'b100, 32'h1000_0000, 12'h013, 32'd0, 5, 0);
        chk(exp_rdata === 32'h0000_00C0, "R8 lbu", exp_rdata, 32'h0000_00C0);
        run_op(2'b01, 3'b001, 32'h1000_0000, 12'h012, 32'd0, 2, 0);
        run_op(2'b01, 3'b101, 32'h1000_0000, 12'h012, 32'd0, 1, 0);
        run_op(2'b01, 3'b001, 32'h1000_0000, 12'h010, 32'd0, 3, 0);
        chk(exp_rdata === 32'hFFFF_EE42, "R8 lh low lane", exp_rdata, 32'hFFFF_EE42);
        run_op(2'b01, 3'b000, 32'h1000_0000, 12'h011, 32'd0, 1, 0);

        // R9 byte store below the stack top, neighbours untouched
        run_op(2'b10, 3'b000, 32'h1200_0000, 12'hFFD, 32'hAABB_CC5A, 3, 0);
        chk(tmem[8'hFD] === 8'h5A, "R9 sb lane", 32'(tmem[8'hFD]), 32'h5A);
        chk({tmem[8'hFC], tmem[8'hFE], tmem[8'hFF]} === 24'h113344, "R9 sb neighbours",
            32'({tmem[8'hFC], tmem[8'hFE], tmem[8'hFF]}), 32'h113344);
        run_op(2'b10, 3'b001, 32'h1200_0000, 12'hFFE, 32'h0000_1234, 2, 0);
        chk({tmem[8'hFF], tmem[8'hFE]} === 16'h1234, "R9 sh lanes", 32'({tmem[8'hFF], tmem[8'hFE]}), 32'h1234);
        chk(tmem[8'hFC] === 8'h11, "R9 sh neighbour", 32'(tmem[8'hFC]), 32'h11);
        run_op(2'b01, 3'b010, 32'h1200_0000, 12'hFFC, 32'd0, 1, 0);
        chk(exp_rdata === 32'h1234_5A11, "R7 R9 readback", exp_rdata, 32'h1234_5A11);
        run_op(2'b10, 3'b010, 32'h1000_0000, 12'h020, 32'hDEAD_BEEF, 1, 0);
        chk({tmem[8'h23], tmem[8'h22], tmem[8'h21], tmem[8'h20]} === 32'hDEAD_BEEF, "R9 sw",
            {tmem[8'h23], tmem[8'h22], tmem[8'h21], tmem[8'h20]}, 32'hDEAD_BEEF);

        // R5 R10 parked with changing inputs
        run_op(2'b01, 3'b010, 32'h1000_0000, 12'h010, 32'd0, 2, 6);
        run_op(2'b10, 3'b000, 32'h1000_0000, 12'h030, 32'h0000_0077, 1, 3);
        chk(tmem[8'h30] === 8'h77 && tmem[8'h70] !== 8'h77, "R5 parked store", 32'(tmem[8'h30]), 32'h77);

        // R2 reserved code behaves as off
        lsu_mode = 2'b11;
        for (int i = 0; i < 4; i++) step();
        lsu_mode = 2'b00;
        step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule